// File: doc/BRIEF.md
# Compact JTAG Escape and Activation Tracker

This block follows the link mode of a two-wire compact JTAG connection from clock-rate samples of the test clock (TCK) and of the shared data/control line (TMSC). While TCK stays high, it counts how often TMSC changes level. On the next rising TCK edge it reads that count as an escape sequence and then clears the count. One escape value starts the online activation sequence. Another value drops the link back to ordinary four-wire operation. Any other value leaves the mode as it is.

During activation, every rising TCK edge is one activation bit. The block reports which field of the sequence that bit belongs to. The TMSC value on the eighth bit picks between a 12-bit sequence and a 36-bit sequence. When the last bit has passed, the block enters the three-slot packet mode. It issues a one-clock request to reset the TAP follower and sets its packet slot pointer to the control slot. All outputs are registered and change in the clock cycle in which the rising TCK edge is first sampled.

Top module: `cjt_link_tracker`

## Requirements
- R1: After reset, mode_o is 0 (four-wire), phase_o is 0 (no phase), slot_o is 0 and tap_rst_o is 0.
- R2: The escape count is the number of TMSC level changes sampled while TCK stays high. It is evaluated only at the next rising TCK edge and cleared there, so two high periods of 3 changes each do not add up to an escape.
- R3: An escape count of exactly 6 sets mode_o to 1 (activation) and restarts the activation bit count. The rising edge that evaluates the escape is activation bit 1, with phase_o 1 (activation code).
- R4: An escape count of 8 or more sets mode_o to 0 from any mode, and phase_o becomes 0.
- R5: Escape counts of 0, 5 and 7 leave the mode unchanged. The change counter saturates instead of wrapping, so 17 changes still count as 8 or more.
- R6: In the 12-bit form, phase_o is 1 for bits 1-4, 2 (extension code) for bits 5-8 and 3 (check packet) for bits 9-12.
- R7: TMSC at 0 on activation bit 8 selects the 36-bit form. TMSC at 1 keeps the 12-bit form.
- R8: In the 36-bit form, bits 1-8 are labelled as in R6. After that, phase_o is 4 for bits 9-13 (spare), 5 for 14-16 (TP delay), 6 for 17-18 (TP revision), 7 for 19-23 (TP state), 8 for 24-25 (ready count), 9 for 26-27 (delay count), 10 for 28-32 (scan format) and 3 for 33-36 (check packet).
- R9: On the first rising edge past the sequence length (bit 13 or bit 37), mode_o becomes 2 (packet mode) and phase_o becomes 0. tap_rst_o is high for exactly one clock cycle.
- R10: On entry to packet mode, slot_o is 1 (control slot). Each later rising TCK edge in packet mode moves it 1 -> 2 (data-out) -> 0 (data-in) -> 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| tck_i | input | 1 | Synchronized test clock sample |
| tmsc_i | input | 1 | Synchronized data/control line sample |
| mode_o | output | 2 | Link mode: 0 four-wire, 1 activation, 2 packet |
| phase_o | output | 4 | Activation field label of the latest bit |
| slot_o | output | 2 | Next packet slot: 0 data-in, 1 control, 2 data-out |
| tap_rst_o | output | 1 | One-cycle TAP reset request on entry to packet mode |

## Verification
The assertions take for granted that tck_i and tmsc_i are already synchronized to clk, and that each TCK level lasts at least one clk sample. They also assume TCK is low when reset is released, so that the first sample does not look like a rising edge. The stimulus keeps TCK low through reset. It holds every TCK level for at least one clock and changes TMSC at most once per clock, only on falling clk edges. It changes TMSC on a rising TCK edge only in the cycle where TCK rises, so that change never counts as part of an escape.

// File: rtl/cjt_pkg.sv
package cjt_pkg;

    typedef enum logic [1:0] {
        LINK_4W    = 2'd0,
        LINK_ACT   = 2'd1,
        LINK_OSCAN = 2'd2
    } link_mode_e;

    typedef enum logic [3:0] {
        PH_NONE     = 4'd0,
        PH_ACT_CODE = 4'd1,
        PH_EXT_CODE = 4'd2,
        PH_CHECK    = 4'd3,
        PH_SPARE    = 4'd4,
        PH_TP_DELAY = 4'd5,
        PH_TP_REV   = 4'd6,
        PH_TP_STATE = 4'd7,
        PH_READY    = 4'd8,
        PH_DELAY    = 4'd9,
        PH_SCAN_FMT = 4'd10
    } act_phase_e;

    typedef enum logic [1:0] {
        SLOT_DIN  = 2'd0,
        SLOT_CTL  = 2'd1,
        SLOT_DOUT = 2'd2
    } pkt_slot_e;

    localparam int ESC_ACT_CNT = 6;
    localparam int ESC_4W_CNT  = 8;
    localparam int SHORT_LEN   = 12;
    localparam int LONG_LEN    = 36;
    localparam int EXT_BIT     = 8;
    localparam int BIT_W       = $clog2(LONG_LEN + 2);

    // last bit number of each field (field ends after this bit)
    localparam int END_ACT   = 4;
    localparam int END_EXT   = 8;
    localparam int END_SPARE = 13;
    localparam int END_TPDEL = 16;
    localparam int END_TPREV = 18;
    localparam int END_TPST  = 23;
    localparam int END_RDY   = 25;
    localparam int END_DLY   = 27;
    localparam int END_FMT   = 32;

    typedef struct packed {
        link_mode_e       mode;
        logic [BIT_W-1:0] bits;
        logic             long_form;
    } act_state_t;

    function automatic act_phase_e phase_of(input logic [BIT_W-1:0] n,
                                            input logic long_form);
        act_phase_e p;
        p = PH_ACT_CODE;
        if (n > BIT_W'(END_ACT)) p = PH_EXT_CODE;
        if (!long_form) begin
            if (n > BIT_W'(END_EXT)) p = PH_CHECK;
        end else begin
            if (n > BIT_W'(END_EXT))   p = PH_SPARE;
            if (n > BIT_W'(END_SPARE)) p = PH_TP_DELAY;
            if (n > BIT_W'(END_TPDEL)) p = PH_TP_REV;
            if (n > BIT_W'(END_TPREV)) p = PH_TP_STATE;
            if (n > BIT_W'(END_TPST))  p = PH_READY;
            if (n > BIT_W'(END_RDY))   p = PH_DELAY;
            if (n > BIT_W'(END_DLY))   p = PH_SCAN_FMT;
            if (n > BIT_W'(END_FMT))   p = PH_CHECK;
        end
        return p;
    endfunction

endpackage

// File: rtl/cjt_escape_counter.sv
module cjt_escape_counter #(
    parameter int ESC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tck_i,
    input  logic             tmsc_i,
    output logic             tck_rise_o,
    output logic [ESC_W-1:0] esc_cnt_o
);
    localparam logic [ESC_W-1:0] CNT_MAX = '1;

    logic             tck_q;
    logic             tmsc_q;
    logic [ESC_W-1:0] cnt_q;
    logic             toggle;

    assign tck_rise_o = tck_i & ~tck_q;
    assign toggle     = tck_i & tck_q & (tmsc_i != tmsc_q);
    assign esc_cnt_o  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tck_q  <= 1'b0;
            tmsc_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            tck_q  <= tck_i;
            tmsc_q <= tmsc_i;
            if (tck_rise_o)
                cnt_q <= '0;
            else if (toggle && cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5
    sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_MAX && !tck_rise_o) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/cjt_act_sequencer.sv
module cjt_act_sequencer
    import cjt_pkg::*;
#(
    parameter int ESC_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tck_rise_i,
    input  logic             tmsc_i,
    input  logic [ESC_W-1:0] esc_cnt_i,
    output link_mode_e       mode_o,
    output act_phase_e       phase_o,
    output logic             tap_rst_o,
    output logic             enter_o,
    output logic             stay_oscan_o
);
    act_state_t cur_q, nxt;
    act_phase_e phase_q;
    logic       tap_rst_q;
    logic       enter;

    always_comb begin
        nxt   = cur_q;
        enter = 1'b0;
        if (tck_rise_i) begin
            if (esc_cnt_i >= ESC_W'(ESC_4W_CNT)) begin
                nxt.mode = LINK_4W;
            end else if (esc_cnt_i == ESC_W'(ESC_ACT_CNT)) begin
                nxt.mode      = LINK_ACT;
                nxt.bits      = '0;
                nxt.long_form = 1'b0;
            end
            if (nxt.mode == LINK_ACT) begin
                nxt.bits = nxt.bits + BIT_W'(1);
                if (nxt.bits == BIT_W'(EXT_BIT) && !tmsc_i)
                    nxt.long_form = 1'b1;
                if (nxt.bits > (nxt.long_form ? BIT_W'(LONG_LEN) : BIT_W'(SHORT_LEN))) begin
                    nxt.mode = LINK_OSCAN;
                    enter    = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= '{mode: LINK_4W, bits: '0, long_form: 1'b0};
            phase_q   <= PH_NONE;
            tap_rst_q <= 1'b0;
        end else begin
            cur_q     <= nxt;
            phase_q   <= (nxt.mode == LINK_ACT) ? phase_of(nxt.bits, nxt.long_form) : PH_NONE;
            tap_rst_q <= enter;
        end
    end

    assign mode_o       = cur_q.mode;
    assign phase_o      = phase_q;
    assign tap_rst_o    = tap_rst_q;
    assign enter_o      = enter;
    assign stay_oscan_o = (cur_q.mode == LINK_OSCAN) && (nxt.mode == LINK_OSCAN);

    // R9
    rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tap_rst_q |-> (cur_q.mode == LINK_OSCAN && $past(cur_q.mode) != LINK_OSCAN));

    // R4
    esc_quit_chk: assert property (@(posedge clk) disable iff (rst)
        (tck_rise_i && esc_cnt_i >= ESC_W'(ESC_4W_CNT)) |=> (cur_q.mode == LINK_4W));

    // R2
    mode_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (cur_q.mode != $past(cur_q.mode)) |-> $past(tck_rise_i));

endmodule

// File: rtl/cjt_slot_tracker.sv
module cjt_slot_tracker
    import cjt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tck_rise_i,
    input  logic      enter_i,
    input  logic      stay_oscan_i,
    output pkt_slot_e slot_o
);
    pkt_slot_e slot_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SLOT_DIN;
        end else if (enter_i) begin
            slot_q <= SLOT_CTL;
        end else if (tck_rise_i && stay_oscan_i) begin
            case (slot_q)
                SLOT_DIN:  slot_q <= SLOT_CTL;
                SLOT_CTL:  slot_q <= SLOT_DOUT;
                default:   slot_q <= SLOT_DIN;
            endcase
        end
    end

    assign slot_o = slot_q;

    // R10
    slot_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (slot_q != $past(slot_q)) |-> $past(tck_rise_i));

endmodule

// File: rtl/cjt_link_tracker.sv
module cjt_link_tracker
    import cjt_pkg::*;
#(
    parameter int ESC_W = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tck_i,
    input  logic       tmsc_i,
    output logic [1:0] mode_o,
    output logic [3:0] phase_o,
    output logic [1:0] slot_o,
    output logic       tap_rst_o
);
    logic             tck_rise;
    logic [ESC_W-1:0] esc_cnt;
    link_mode_e       mode;
    act_phase_e       phase;
    pkt_slot_e        slot;
    logic             enter;
    logic             stay_oscan;
    logic             tap_rst;

    cjt_escape_counter #(.ESC_W(ESC_W)) esc_i (
        .clk        (clk),
        .rst        (rst),
        .tck_i      (tck_i),
        .tmsc_i     (tmsc_i),
        .tck_rise_o (tck_rise),
        .esc_cnt_o  (esc_cnt)
    );

    cjt_act_sequencer #(.ESC_W(ESC_W)) seq_i (
        .clk          (clk),
        .rst          (rst),
        .tck_rise_i   (tck_rise),
        .tmsc_i       (tmsc_i),
        .esc_cnt_i    (esc_cnt),
        .mode_o       (mode),
        .phase_o      (phase),
        .tap_rst_o    (tap_rst),
        .enter_o      (enter),
        .stay_oscan_o (stay_oscan)
    );

    cjt_slot_tracker slot_i (
        .clk          (clk),
        .rst          (rst),
        .tck_rise_i   (tck_rise),
        .enter_i      (enter),
        .stay_oscan_i (stay_oscan),
        .slot_o       (slot)
    );

    assign mode_o    = mode;
    assign phase_o   = phase;
    assign slot_o    = slot;
    assign tap_rst_o = tap_rst;

endmodule

// File: tb/cjt_link_tracker_tb_top.sv
`timescale 1ns/1ps
module cjt_link_tracker_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tck = 1'b0;
    logic       tmsc = 1'b0;
    logic [1:0] mode_o;
    logic [3:0] phase_o;
    logic [1:0] slot_o;
    logic       tap_rst_o;
    logic       seen_rst;
    int         n_chk = 0;
    int         n_fail = 0;

    cjt_link_tracker dut_i (
        .clk       (clk),
        .rst       (rst),
        .tck_i     (tck),
        .tmsc_i    (tmsc),
        .mode_o    (mode_o),
        .phase_o   (phase_o),
        .slot_o    (slot_o),
        .tap_rst_o (tap_rst_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one TCK high period with n TMSC changes, then TCK low
    task automatic hi(input logic v, input int n);
        @(negedge clk);
        tmsc = v;
        tck  = 1'b1;
        @(negedge clk);
        seen_rst = tap_rst_o;
        for (int i = 0; i < n; i++) begin
            tmsc = ~tmsc;
            @(negedge clk);
        end
        tck = 1'b0;
        @(negedge clk);
    endtask

    function automatic int exp_phase(input int k, input bit long_form);
        if (k <= 4) return 1;
        if (k <= 8) return 2;
        if (!long_form) return 3;
        if (k <= 13) return 4;
        if (k <= 16) return 5;
        if (k <= 18) return 6;
        if (k <= 23) return 7;
        if (k <= 25) return 8;
        if (k <= 27) return 9;
        if (k <= 32) return 10;
        return 3;
    endfunction

    task automatic t_reset();
        chk("R1 mode", mode_o, 0);
        chk("R1 phase", phase_o, 0);
        chk("R1 slot", slot_o, 0);
        chk("R1 tap_rst", tap_rst_o, 0);
    endtask

    task automatic t_no_escape();
        hi(1'b1, 0); hi(1'b0, 0);
        chk("R5 zero changes", mode_o, 0);
        hi(1'b1, 5); hi(1'b1, 0);
        chk("R5 five changes", mode_o, 0);
        hi(1'b1, 7); hi(1'b1, 0);
        chk("R5 seven changes", mode_o, 0);
        hi(1'b1, 3); hi(1'b1, 3); hi(1'b1, 0);
        chk("R2 split changes", mode_o, 0);
    endtask

    task automatic t_activate(input bit long_form);
        int last;
        last = long_form ? 36 : 12;
        hi(1'b1, 6);
        for (int k = 1; k <= last; k++) begin
            hi((k == 8) ? ~long_form : 1'b1, 0);
            if (k == 1) chk("R3 mode", mode_o, 1);
            chk(long_form ? "R8 phase" : "R6 phase", phase_o, exp_phase(k, long_form));
            if (k == 8) chk("R7 mode at bit 8", mode_o, 1);
        end
        chk("R7 still active at last bit", mode_o, 1);
        hi(1'b1, 0);
        chk("R9 mode", mode_o, 2);
        chk("R9 phase", phase_o, 0);
        chk("R9 pulse high", seen_rst, 1);
        chk("R9 pulse one cycle", tap_rst_o, 0);
        chk("R10 preset slot", slot_o, 1);
    endtask

    task automatic t_slots();
        hi(1'b0, 0); chk("R10 slot step 1", slot_o, 2);
        hi(1'b0, 0); chk("R10 slot step 2", slot_o, 0);
        hi(1'b0, 0); chk("R10 slot step 3", slot_o, 1);
        chk("R10 mode held", mode_o, 2);
        chk("R9 no repeat pulse", seen_rst, 0);
    endtask

    task automatic t_quit_oscan();
        hi(1'b1, 8); hi(1'b1, 0);
        chk("R4 quit from packet", mode_o, 0);
        chk("R4 phase", phase_o, 0);
    endtask

    task automatic t_saturate();
        hi(1'b1, 6); hi(1'b1, 0);
        chk("R3 re-enter", mode_o, 1);
        hi(1'b1, 17); hi(1'b1, 0);
        chk("R5 saturating count", mode_o, 0);
        chk("R4 phase cleared", phase_o, 0);
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_no_escape();
        t_activate(1'b0);
        t_slots();
        t_quit_oscan();
        t_activate(1'b1);
        t_quit_oscan();
        t_saturate();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule